// File: doc/BRIEF.md
# Packet stream receive decoder

This block sits behind a link's character decoder and word aligner. Once per slow clock it receives a 32-bit double word in which every byte carries a flag that marks it as a control character. It sorts each double word into one of four kinds. A fill double word separates packets. A command double word carries a 16-bit payload on the same channel as the data. A data double word holds two 16-bit words. Any other use of control characters is a protocol fault.

Data double words are split into their two halves and played out on a fast clock that runs at twice the slow rate, with a valid strobe. The upper half goes out first. A start-of-packet flag marks the first word that follows one or more fill double words. Command payloads appear on a separate output with a one-slow-cycle strobe. Fill double words produce no output, and faulty double words raise a one-cycle error pulse and are dropped. The two clocks are assumed to be phase-aligned, with every slow rising edge falling on a fast rising edge.

Top module: `rx_stream_decoder`

## Requirements
- R1: A double word equal to 0xBC1CBC1C with all four control flags set is a fill word: it drives no half word, no command strobe and no error pulse.
- R2: A double word with byte 3 (bits 31:24) equal to 0xFD and flagged, and bytes 2..0 unflagged, is a command. On the slow edge that captures it, op_valid is set for one slow cycle and op_payload takes bits 15:0. Byte 2 is ignored.
- R3: A double word with no control flag set is data. Its bits 31:16 appear on half_word with half_valid on the first fast edge after the capturing slow edge. Its bits 15:0 follow on the next fast edge. No other half words are emitted.
- R4: Data double words on consecutive slow cycles give an unbroken run of half_valid, and every run has an even number of beats.
- R5: half_sop is set with the upper half of the first data double word after at least one fill word. Command and faulty double words between the fill and the data keep the mark. Reset clears the mark, and half_sop is never set on a lower half.
- R6: Any other double word with at least one control flag set raises proto_err for exactly one slow cycle, never together with op_valid, and produces no other output.
- R7: While rst is high, and directly after it is released, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Double-word clock, half the fast rate, phase-aligned |
| clk_fast | input | 1 | Half-word output clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| rx_word | input | 8*BYTES (32) | Decoded double word, byte 3 in the top bits |
| rx_kflag | input | BYTES (4) | Control-character flag for each byte |
| half_word | output | 4*BYTES (16) | Output data word, fast domain |
| half_valid | output | 1 | half_word carries data this fast cycle |
| half_sop | output | 1 | First word of a packet |
| op_payload | output | 8*(BYTES-2) (16) | Command payload, slow domain |
| op_valid | output | 1 | One-slow-cycle command strobe |
| proto_err | output | 1 | One-slow-cycle protocol fault pulse |

## Verification
The bench builds the block with its default BYTES = 4. At that size, all sixteen control-flag masks can be crossed with every double-word shape: fill, command, data, near-miss fill and near-miss command marker. Packet streams of one to five data double words, separated by zero to three fill words, exercise the start-of-packet mark, gapless playout and the exact fast-edge latency of both halves.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam logic [7:0] CH_COMMA  = 8'hBC;
  localparam logic [7:0] CH_FILL   = 8'h1C;
  localparam logic [7:0] CH_OPMARK = 8'hFD;

  typedef enum logic [1:0] {
    DW_IDLE   = 2'd0,
    DW_OPCODE = 2'd1,
    DW_DATA   = 2'd2,
    DW_BAD    = 2'd3
  } dw_kind_t;
endpackage

// File: rtl/rxs_dw_classify.sv
module rxs_dw_classify
  import rxs_pkg::*;
#(
  parameter  int BYTES = 4,
  localparam int DW_W  = 8 * BYTES
) (
  input  logic [DW_W-1:0]  word,
  input  logic [BYTES-1:0] kflag,
  output dw_kind_t         kind
);
  logic [BYTES-1:0] idle_hit;
  logic [BYTES-1:0] op_hit;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    // odd lanes carry the comma, even lanes the filler character
    localparam logic [7:0] IDLE_CH = (i % 2 == 1) ? CH_COMMA : CH_FILL;
    assign idle_hit[i] = kflag[i] && (word[8*i +: 8] == IDLE_CH);
    if (i == BYTES - 1) begin : g_top
      assign op_hit[i] = kflag[i] && (word[8*i +: 8] == CH_OPMARK);
    end else begin : g_low
      assign op_hit[i] = !kflag[i];
    end
  end

  always_comb begin
    if (kflag == '0)   kind = DW_DATA;
    else if (&idle_hit) kind = DW_IDLE;
    else if (&op_hit)   kind = DW_OPCODE;
    else                kind = DW_BAD;
  end
endmodule

// File: rtl/rxs_slow_stage.sv
module rxs_slow_stage
  import rxs_pkg::*;
#(
  parameter  int BYTES = 4,
  localparam int DW_W  = 8 * BYTES,
  localparam int OP_W  = 8 * (BYTES - 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW_W-1:0] word,
  input  dw_kind_t        kind,
  output logic [DW_W-1:0] dw_hold,
  output logic            dw_sop,
  output logic            dw_tog,
  output logic [OP_W-1:0] op_payload,
  output logic            op_valid,
  output logic            proto_err
);
  logic seen_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      dw_hold    <= '0;
      dw_sop     <= 1'b0;
      dw_tog     <= 1'b0;
      op_payload <= '0;
      op_valid   <= 1'b0;
      proto_err  <= 1'b0;
      seen_idle  <= 1'b0;
    end else begin
      op_valid  <= 1'b0;
      proto_err <= 1'b0;
      case (kind)
        DW_IDLE: seen_idle <= 1'b1;
        DW_OPCODE: begin
          op_valid   <= 1'b1;
          op_payload <= word[OP_W-1:0];
        end
        DW_DATA: begin
          dw_hold   <= word;
          dw_sop    <= seen_idle;
          seen_idle <= 1'b0;
          dw_tog    <= ~dw_tog;
        end
        default: proto_err <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rxs_half_split.sv
module rxs_half_split #(
  parameter  int BYTES  = 4,
  localparam int DW_W   = 8 * BYTES,
  localparam int HALF_W = DW_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW_W-1:0]   dw_hold,
  input  logic              dw_sop,
  input  logic              dw_tog,
  output logic [HALF_W-1:0] half_word,
  output logic              half_valid,
  output logic              half_sop
);
  logic              tog_seen;
  logic              lo_due;
  logic [HALF_W-1:0] lo_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_seen   <= 1'b0;
      lo_due     <= 1'b0;
      lo_pend    <= '0;
      half_word  <= '0;
      half_valid <= 1'b0;
      half_sop   <= 1'b0;
    end else if (dw_tog != tog_seen) begin
      tog_seen   <= dw_tog;
      half_word  <= dw_hold[DW_W-1:HALF_W];
      lo_pend    <= dw_hold[HALF_W-1:0];
      lo_due     <= 1'b1;
      half_valid <= 1'b1;
      half_sop   <= dw_sop;
    end else if (lo_due) begin
      half_word  <= lo_pend;
      lo_due     <= 1'b0;
      half_valid <= 1'b1;
      half_sop   <= 1'b0;
    end else begin
      half_valid <= 1'b0;
      half_sop   <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_stream_decoder.sv
module rx_stream_decoder
  import rxs_pkg::*;
#(
  parameter  int BYTES  = 4,
  localparam int DW_W   = 8 * BYTES,
  localparam int HALF_W = DW_W / 2,
  localparam int OP_W   = 8 * (BYTES - 2)
) (
  input  logic              clk_slow,
  input  logic              clk_fast,
  input  logic              rst,
  input  logic [DW_W-1:0]   rx_word,
  input  logic [BYTES-1:0]  rx_kflag,
  output logic [HALF_W-1:0] half_word,
  output logic              half_valid,
  output logic              half_sop,
  output logic [OP_W-1:0]   op_payload,
  output logic              op_valid,
  output logic              proto_err
);
  dw_kind_t        kind;
  logic [DW_W-1:0] dw_hold;
  logic            dw_sop;
  logic            dw_tog;

  rxs_dw_classify #(.BYTES(BYTES)) u_classify (
    .word  (rx_word),
    .kflag (rx_kflag),
    .kind  (kind)
  );

  rxs_slow_stage #(.BYTES(BYTES)) u_slow (
    .clk        (clk_slow),
    .rst        (rst),
    .word       (rx_word),
    .kind       (kind),
    .dw_hold    (dw_hold),
    .dw_sop     (dw_sop),
    .dw_tog     (dw_tog),
    .op_payload (op_payload),
    .op_valid   (op_valid),
    .proto_err  (proto_err)
  );

  rxs_half_split #(.BYTES(BYTES)) u_split (
    .clk        (clk_fast),
    .rst        (rst),
    .dw_hold    (dw_hold),
    .dw_sop     (dw_sop),
    .dw_tog     (dw_tog),
    .half_word  (half_word),
    .half_valid (half_valid),
    .half_sop   (half_sop)
  );
endmodule

// File: rtl/rx_stream_decoder_chk.sv
module rx_stream_decoder_chk #(
  parameter  int BYTES  = 4,
  localparam int DW_W   = 8 * BYTES,
  localparam int HALF_W = DW_W / 2,
  localparam int OP_W   = 8 * (BYTES - 2)
) (
  input logic              clk_slow,
  input logic              clk_fast,
  input logic              rst,
  input logic [DW_W-1:0]   rx_word,
  input logic [BYTES-1:0]  rx_kflag,
  input logic [HALF_W-1:0] half_word,
  input logic              half_valid,
  input logic              half_sop,
  input logic [OP_W-1:0]   op_payload,
  input logic              op_valid,
  input logic              proto_err
);
  logic odd_beat;

  always_ff @(posedge clk_fast) begin
    if (rst) odd_beat <= 1'b0;
    else if (half_valid) odd_beat <= ~odd_beat;
  end

  // R6: a fault pulse follows only a double word that had a control flag
  p_err_needs_k_r6: assert property (@(posedge clk_slow) disable iff (rst)
    proto_err |-> ($past(rx_kflag) != '0));

  // R2: a command strobe follows only a flagged marker in the top byte
  p_op_marker_r2: assert property (@(posedge clk_slow) disable iff (rst)
    op_valid |-> ($past(rx_word[DW_W-1 -: 8]) == 8'hFD && $past(rx_kflag[BYTES-1])));

  // R6: fault and command strobes never coincide
  p_op_err_excl_r6: assert property (@(posedge clk_slow) disable iff (rst)
    !(op_valid && proto_err));

  // R4: every valid run holds an even number of beats
  p_pair_beats_r4: assert property (@(posedge clk_fast) disable iff (rst)
    !half_valid |-> !odd_beat);

  // R5: start of packet only on a valid upper half
  p_sop_first_r5: assert property (@(posedge clk_fast) disable iff (rst)
    half_sop |-> (half_valid && !odd_beat));
endmodule

bind rx_stream_decoder rx_stream_decoder_chk #(.BYTES(BYTES)) u_chk (
  .clk_slow   (clk_slow),
  .clk_fast   (clk_fast),
  .rst        (rst),
  .rx_word    (rx_word),
  .rx_kflag   (rx_kflag),
  .half_word  (half_word),
  .half_valid (half_valid),
  .half_sop   (half_sop),
  .op_payload (op_payload),
  .op_valid   (op_valid),
  .proto_err  (proto_err)
);

// File: tb/rx_stream_decoder_bench.sv
module rx_stream_decoder_bench;
  localparam int BYTES = 4;
  localparam logic [31:0] FILL = 32'hBC1CBC1C;

  logic        clk_fast = 1'b0;
  logic        clk_slow = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rx_word = '0;
  logic [3:0]  rx_kflag = '0;
  logic [15:0] half_word;
  logic        half_valid;
  logic        half_sop;
  logic [15:0] op_payload;
  logic        op_valid;
  logic        proto_err;

  int n_tests = 0;
  int n_fail = 0;
  logic [15:0] q_word [0:4095];
  logic        q_sop  [0:4095];
  int q_wr = 0;
  int q_rd = 0;
  bit seen_idle = 1'b0;
  bit prev_data = 1'b0;
  bit run_mon = 1'b0;
  logic [15:0] prev_lo = '0;

  rx_stream_decoder #(.BYTES(BYTES)) u_rx_stream_decoder (
    .clk_slow   (clk_slow),
    .clk_fast   (clk_fast),
    .rst        (rst),
    .rx_word    (rx_word),
    .rx_kflag   (rx_kflag),
    .half_word  (half_word),
    .half_valid (half_valid),
    .half_sop   (half_sop),
    .op_payload (op_payload),
    .op_valid   (op_valid),
    .proto_err  (proto_err)
  );

  initial forever #2 clk_fast = ~clk_fast;
  initial begin
    #2;
    forever begin
      clk_slow = 1'b1; #4;
      clk_slow = 1'b0; #4;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_fast) begin
    if (!rst && run_mon) begin
      if (half_valid) begin
        if (q_rd == q_wr) begin
          n_tests++; n_fail++;
          $display("FAIL R3 stray half word: got %h expected none", half_word);
        end else begin
          check("R3", "half word", half_word, q_word[q_rd % 4096]);
          check("R5", "sop flag", half_sop, q_sop[q_rd % 4096]);
          q_rd++;
        end
      end else if (half_sop) begin
        check("R5", "sop without valid", half_sop, 0);
      end
    end
  end

  task automatic send(input logic [31:0] w, input logic [3:0] k);
    bit is_data, is_idle, is_op;
    is_data = (k == 4'h0);
    is_idle = (k == 4'hF) && (w == FILL);
    is_op   = (k == 4'b1000) && (w[31:24] == 8'hFD);
    rx_word  = w;
    rx_kflag = k;
    @(posedge clk_slow);
    #2;
    if (is_data) begin
      q_word[q_wr % 4096] = w[31:16]; q_sop[q_wr % 4096] = seen_idle; q_wr++;
      q_word[q_wr % 4096] = w[15:0];  q_sop[q_wr % 4096] = 1'b0;      q_wr++;
      seen_idle = 1'b0;
      check("R3", "no strobe on data", {op_valid, proto_err}, 0);
      if (prev_data) begin
        check("R4", "gapless lower half", {half_valid, half_word}, {1'b1, prev_lo});
      end
      #4;
      check("R3", "upper half latency", {half_valid, half_word}, {1'b1, w[31:16]});
      prev_lo = w[15:0];
    end else if (is_idle) begin
      seen_idle = 1'b1;
      check("R1", "fill is silent", {op_valid, proto_err}, 0);
    end else if (is_op) begin
      check("R2", "command strobe", {op_valid, proto_err}, 2'b10);
      check("R2", "command payload", op_payload, w[15:0]);
    end else begin
      check("R6", "fault pulse", {op_valid, proto_err}, 2'b01);
    end
    prev_data = is_data;
  endtask

  task automatic settle_silent(input string req);
    rx_word = '0; rx_kflag = 4'hF;
    @(posedge clk_slow); #2;
    check(req, "fault pulse is one cycle", {op_valid, proto_err}, 2'b01);
    rx_word = FILL;
    @(posedge clk_slow); #2;
    check(req, "strobes clear", {op_valid, proto_err}, 0);
    seen_idle = 1'b1;
    prev_data = 1'b0;
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_slow);
    #2;
    check("R7", "outputs in reset",
          {half_word, half_valid, half_sop, op_payload, op_valid, proto_err}, 0);
    rst = 1'b0;
    check("R7", "outputs after reset",
          {half_word, half_valid, half_sop, op_payload, op_valid, proto_err}, 0);
    run_mon = 1'b1;

    // R5: reset leaves the packet mark clear
    send(32'h0102_0304, 4'h0);

    // R1 R2 R3 R6: every flag mask against every double-word shape
    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < 6; p++) begin
        logic [31:0] w;
        case (p)
          0: w = FILL;
          1: w = {8'hFD, 8'(k * 17), 8'(k * 3 + 1), 8'(8'hA5 - k)};
          2: w = (k * 6 + p + 1) * 32'h0103_0507;
          3: w = 32'hBC1C_BC1D;
          4: w = {8'hFC, 8'(k), 16'h1234};
          default: w = 32'h1CBC_1CBC;
        endcase
        if ((k + p) % 3 == 0) send(FILL, 4'hF);
        send(w, 4'(k));
      end
    end

    // R4 R5: packets of 1..5 data double words after 0..3 fill words
    for (int gap = 0; gap < 4; gap++) begin
      for (int len = 1; len <= 5; len++) begin
        for (int g = 0; g < gap; g++) send(FILL, 4'hF);
        for (int i = 0; i < len; i++)
          send(((gap * 8 + len) << 24) + i * 32'h0001_0203 + 32'h0000_4000, 4'h0);
      end
    end

    // R5: command or fault between fill and data keeps the mark
    send(FILL, 4'hF);
    send(32'hFD00_BEEF, 4'b1000);
    send(32'h5555_AAAA, 4'h0);
    send(FILL, 4'hF);
    send(32'hFFFF_FFFF, 4'b0100);
    send(32'h6666_9999, 4'h0);
    // R5: command alone does not set the mark
    send(32'hFD11_CAFE, 4'b1000);
    send(32'h7777_8888, 4'h0);

    // R6: fault pulse lasts one slow cycle
    settle_silent("R6");

    repeat (6) @(posedge clk_fast);
    #1;
    check("R3", "all halves delivered", q_rd, q_wr);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule